// File: doc/BRIEF.md
# Selectable Processor Clock Divider

This block turns a 480 MHz PLL clock into the processor clock. A two-bit speed field picks one of three rates, 48, 24 or 12 MHz, which are divide ratios of 10, 20 and 40. The rate after reset is 12 MHz. The speed field can be rewritten at any time without a reset. The divider moves to a new ratio only at the end of a complete low phase, so the processor never sees a shortened pulse.

The block has three clock outputs: the divided clock as a registered square wave, a one-cycle clock-enable pulse in the PLL domain, and a pad output with its output-enable. The pad carries the same square wave at 50% duty cycle. One control bit inverts it. Another control bit turns the driver off, and while the driver is off the pad data is held at 0. All control fields are plain inputs, sampled on the PLL clock. Reset is asserted asynchronously and released in step with the PLL clock.

Top module: `cpu_clk_div`

## Requirements
- R1: While reset is asserted, `cpu_clk`, `cpu_clk_en`, `clkout_pad` and `clkout_oe` are all 0.
- R2: Speed field 2'b00 gives a period of 40 PLL cycles, made of 20 high and 20 low. This is also the rate after reset.
- R3: Speed field 2'b01 gives a period of 20 PLL cycles (10 high, 10 low). Speed field 2'b10 gives a period of 10 PLL cycles (5 high, 5 low).
- R4: The reserved speed field value 2'b11 behaves exactly like 2'b00, with 20 high and 20 low.
- R5: After any run-time change of the speed field, every high and low phase lasts a full half-period of either the old rate or the new rate. Within each period the high time equals the low time. From the fourth complete period after the change onward, only the new rate appears.
- R6: `cpu_clk_en` is high for exactly one PLL cycle per period. That cycle is the last low cycle, so `cpu_clk` rises on the following edge.
- R7: With the driver on and the invert bit set, `clkout_pad` equals the inverse of `cpu_clk`. The pad follows a change of a control bit within two PLL edges.
- R8: With the high-impedance bit set, `clkout_oe` is 0 and `clkout_pad` is 0.
- R9: With the driver on and the invert bit clear, `clkout_pad` equals `cpu_clk` and `clkout_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_pll | input | 1 | 480 MHz PLL clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_sel | input | 2 | Rate select: 00 = 12 MHz, 01 = 24 MHz, 10 = 48 MHz, 11 = 12 MHz |
| clkout_inv | input | 1 | Inverts the pad output when set |
| clkout_hiz | input | 1 | Turns the pad driver off and holds the pad data at 0 |
| cpu_clk | output | 1 | Divided processor clock, registered |
| cpu_clk_en | output | 1 | One-cycle pulse in the last low cycle of each period |
| clkout_pad | output | 1 | Pad data for the clock-output pin |
| clkout_oe | output | 1 | Pad output-enable |

## Verification
The hardest case to reach from the ports is a speed change that lands close to the period boundary. There the request register and the wrap point compete, and a careless divider would emit a shortened phase. The stimulus therefore steps through every ordered pair of distinct rates. It issues each change at several fixed offsets after a rising edge, including offsets that fall in the last low cycles of the old period. It then measures four complete periods and checks each phase against the old and the new half-period.

// File: rtl/cpu_clk_pkg.sv
package cpu_clk_pkg;

  typedef enum logic [1:0] {
    RATE_SLOW = 2'd0,
    RATE_MID  = 2'd1,
    RATE_FAST = 2'd2
  } rate_e;

  // 01 -> mid, 10 -> fast, 00 and the reserved 11 -> slow
  function automatic rate_e decode_speed(input logic [1:0] field);
    rate_e r;
    case (field)
      2'b01:   r = RATE_MID;
      2'b10:   r = RATE_FAST;
      default: r = RATE_SLOW;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cpu_clk_rst_sync.sv
module cpu_clk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/cpu_clk_ctl_reg.sv
module cpu_clk_ctl_reg #(
  parameter int unsigned     W   = 4,
  parameter logic [W-1:0]    RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bit_q <= RST[i];
      else        bit_q <= d[i];
    end
    assign q[i] = bit_q;
  end

endmodule

// File: rtl/cpu_clk_div_core.sv
module cpu_clk_div_core
  import cpu_clk_pkg::*;
#(
  parameter int unsigned FAST_DIV = 10
) (
  input  logic  clk,
  input  logic  rst_n,
  input  rate_e rate_req,
  output logic  cpu_clk,
  output logic  cpu_clk_en,
  output logic  hi_next
);

  localparam int unsigned HALF_FAST   = FAST_DIV / 2;
  localparam int unsigned HALF_MID    = FAST_DIV;
  localparam int unsigned HALF_SLOW   = 2 * FAST_DIV;
  localparam int unsigned PERIOD_SLOW = 2 * HALF_SLOW;
  localparam int unsigned CW          = $clog2(PERIOD_SLOW + 1);

  typedef logic [CW-1:0] cnt_t;

  localparam cnt_t HALF_F = cnt_t'(HALF_FAST);
  localparam cnt_t HALF_M = cnt_t'(HALF_MID);
  localparam cnt_t HALF_S = cnt_t'(HALF_SLOW);
  localparam cnt_t LAST_S = cnt_t'(PERIOD_SLOW - 1);

  cnt_t cnt_q, cnt_d;
  cnt_t half_q, half_d;
  cnt_t half_req;
  cnt_t last_cur, last_nxt;
  logic hi_q, hi_d;
  logic en_q, en_d;
  logic wrap;

  // requested half-period
  always_comb begin
    case (rate_req)
      RATE_FAST: half_req = HALF_F;
      RATE_MID:  half_req = HALF_M;
      default:   half_req = HALF_S;
    endcase
  end

  // next state: the ratio is swapped only at the wrap (end of a low phase)
  always_comb begin
    last_cur = (half_q << 1) - cnt_t'(1);
    wrap     = (cnt_q == last_cur);
    cnt_d    = wrap ? '0 : cnt_q + cnt_t'(1);
    half_d   = wrap ? half_req : half_q;
    hi_d     = (cnt_d < half_d);
    last_nxt = (half_d << 1) - cnt_t'(1);
    en_d     = (cnt_d == last_nxt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= LAST_S;
      half_q <= HALF_S;
      hi_q   <= 1'b0;
      en_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      half_q <= half_d;
      hi_q   <= hi_d;
      en_q   <= en_d;
    end
  end

  assign cpu_clk    = hi_q;
  assign cpu_clk_en = en_q;
  assign hi_next    = hi_d;

endmodule

// File: rtl/cpu_clk_pad_ctl.sv
module cpu_clk_pad_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic hi_next,
  input  logic inv,
  input  logic hiz,
  output logic pad,
  output logic oe
);

  logic pad_q, pad_d;
  logic oe_q, oe_d;

  always_comb begin
    pad_d = hiz ? 1'b0 : (hi_next ^ inv);
    oe_d  = ~hiz;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      pad_q <= pad_d;
      oe_q  <= oe_d;
    end
  end

  assign pad = pad_q;
  assign oe  = oe_q;

endmodule

// File: rtl/cpu_clk_div.sv
module cpu_clk_div
  import cpu_clk_pkg::*;
#(
  parameter int unsigned FAST_DIV = 10
) (
  input  logic       clk_pll,
  input  logic       rst_n,
  input  logic [1:0] speed_sel,
  input  logic       clkout_inv,
  input  logic       clkout_hiz,
  output logic       cpu_clk,
  output logic       cpu_clk_en,
  output logic       clkout_pad,
  output logic       clkout_oe
);

  localparam int unsigned CTL_W = 4;
  localparam logic [CTL_W-1:0] CTL_RST = 4'b1000;

  logic             rst_n_int;
  logic [CTL_W-1:0] ctl_q;
  logic             hi_next;
  rate_e            rate_req;

  cpu_clk_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk_pll),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  cpu_clk_ctl_reg #(.W(CTL_W), .RST(CTL_RST)) u_ctl (
    .clk   (clk_pll),
    .rst_n (rst_n_int),
    .d     ({clkout_hiz, clkout_inv, speed_sel}),
    .q     (ctl_q)
  );

  assign rate_req = decode_speed(ctl_q[1:0]);

  cpu_clk_div_core #(.FAST_DIV(FAST_DIV)) u_core (
    .clk        (clk_pll),
    .rst_n      (rst_n_int),
    .rate_req   (rate_req),
    .cpu_clk    (cpu_clk),
    .cpu_clk_en (cpu_clk_en),
    .hi_next    (hi_next)
  );

  cpu_clk_pad_ctl u_pad (
    .clk     (clk_pll),
    .rst_n   (rst_n_int),
    .hi_next (hi_next),
    .inv     (ctl_q[2]),
    .hiz     (ctl_q[3]),
    .pad     (clkout_pad),
    .oe      (clkout_oe)
  );

endmodule

// File: rtl/cpu_clk_div_chk.sv
module cpu_clk_div_chk #(
  parameter int unsigned FAST_DIV = 10
) (
  input logic clk_pll,
  input logic rst_n,
  input logic clkout_hiz,
  input logic cpu_clk,
  input logic cpu_clk_en,
  input logic clkout_pad,
  input logic clkout_oe
);

  localparam int unsigned HF = FAST_DIV / 2;
  localparam int unsigned HM = FAST_DIV;
  localparam int unsigned HS = 2 * FAST_DIV;
  localparam int unsigned RW = $clog2(4 * FAST_DIV + 1) + 1;

  logic [RW-1:0] run_len_q;
  logic          prev_q;
  logic          seen_rise_q;
  logic          seen_fall_q;
  logic [1:0]    age_q;

  always_ff @(posedge clk_pll or negedge rst_n) begin
    if (!rst_n) begin
      run_len_q   <= '0;
      prev_q      <= 1'b0;
      seen_rise_q <= 1'b0;
      seen_fall_q <= 1'b0;
      age_q       <= '0;
    end else begin
      prev_q    <= cpu_clk;
      run_len_q <= (cpu_clk != prev_q) ? RW'(1) : run_len_q + RW'(1);
      if (cpu_clk && !prev_q) seen_rise_q <= 1'b1;
      if (!cpu_clk && prev_q) seen_fall_q <= 1'b1;
      if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end
  end

  function automatic logic legal_half(input logic [RW-1:0] n);
    return (n == RW'(HF)) || (n == RW'(HM)) || (n == RW'(HS));
  endfunction

  assert_en_then_rise_R6: assert property (@(posedge clk_pll) disable iff (!rst_n)
    cpu_clk_en |=> $rose(cpu_clk));

  assert_rise_after_en_R6: assert property (@(posedge clk_pll) disable iff (!rst_n)
    (seen_rise_q && $rose(cpu_clk)) |-> $past(cpu_clk_en));

  assert_high_len_R5: assert property (@(posedge clk_pll) disable iff (!rst_n)
    $fell(cpu_clk) |-> legal_half(run_len_q));

  assert_low_len_R5: assert property (@(posedge clk_pll) disable iff (!rst_n)
    (seen_fall_q && $rose(cpu_clk)) |-> legal_half(run_len_q));

  assert_hiz_pad_low_R8: assert property (@(posedge clk_pll) disable iff (!rst_n)
    !clkout_oe |-> !clkout_pad);

  assert_hiz_oe_off_R8: assert property (@(posedge clk_pll) disable iff (!rst_n)
    ((age_q == 2'd3) && $past(clkout_hiz, 2)) |-> !clkout_oe);

endmodule

bind cpu_clk_div cpu_clk_div_chk #(.FAST_DIV(FAST_DIV)) u_chk (
  .clk_pll    (clk_pll),
  .rst_n      (rst_n),
  .clkout_hiz (clkout_hiz),
  .cpu_clk    (cpu_clk),
  .cpu_clk_en (cpu_clk_en),
  .clkout_pad (clkout_pad),
  .clkout_oe  (clkout_oe)
);

// File: tb/sim_cpu_clk_div.sv
module sim_cpu_clk_div;
  timeunit 1ns;
  timeprecision 100ps;

  localparam real CLK_PERIOD = 2.0;
  localparam int  FAST_DIV   = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] speed_sel;
  logic       clkout_inv;
  logic       clkout_hiz;
  logic       cpu_clk, cpu_clk_en, clkout_pad, clkout_oe;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2.0) clk = ~clk;

  cpu_clk_div #(.FAST_DIV(FAST_DIV)) u0 (
    .clk_pll    (clk),
    .rst_n      (rst_n),
    .speed_sel  (speed_sel),
    .clkout_inv (clkout_inv),
    .clkout_hiz (clkout_hiz),
    .cpu_clk    (cpu_clk),
    .cpu_clk_en (cpu_clk_en),
    .clkout_pad (clkout_pad),
    .clkout_oe  (clkout_oe)
  );

  function automatic int half_of(input logic [1:0] code);
    case (code)
      2'b01:   return FAST_DIV;
      2'b10:   return FAST_DIV / 2;
      default: return 2 * FAST_DIV;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Measures one full period starting at a rising edge
  task automatic grab(output int hi, output int lo, output int en_cnt, output int en_last);
    hi = 0; lo = 0; en_cnt = 0; en_last = 0;
    @(negedge clk);
    while (cpu_clk) @(negedge clk);
    while (!cpu_clk) @(negedge clk);
    while (cpu_clk) begin
      hi++; en_cnt += int'(cpu_clk_en); @(negedge clk);
    end
    while (!cpu_clk) begin
      lo++; en_cnt += int'(cpu_clk_en); en_last = int'(cpu_clk_en); @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int hi, lo, ec, el;
    int offs[4] = '{0, 7, 18, 37};
    rst_n = 1'b0; speed_sel = 2'b00; clkout_inv = 1'b0; clkout_hiz = 1'b0;
    repeat (5) @(negedge clk);
    // R1: reset state
    chk(cpu_clk == 0, "R1 cpu_clk", int'(cpu_clk), 0);
    chk(cpu_clk_en == 0, "R1 cpu_clk_en", int'(cpu_clk_en), 0);
    chk(clkout_pad == 0, "R1 clkout_pad", int'(clkout_pad), 0);
    chk(clkout_oe == 0, "R1 clkout_oe", int'(clkout_oe), 0);
    rst_n = 1'b1;

    // R2: default rate right after reset
    grab(hi, lo, ec, el);
    chk(hi == 20, "R2 default high", hi, 20);
    chk(lo == 20, "R2 default low", lo, 20);

    // R2 R3 R4 R6: static sweep over every speed code
    for (int c = 0; c < 4; c++) begin
      speed_sel = 2'(c);
      repeat (100) @(negedge clk);
      for (int p = 0; p < 3; p++) begin
        grab(hi, lo, ec, el);
        chk(hi == half_of(2'(c)), c == 3 ? "R4 high" : (c == 0 ? "R2 high" : "R3 high"), hi, half_of(2'(c)));
        chk(lo == half_of(2'(c)), c == 3 ? "R4 low" : (c == 0 ? "R2 low" : "R3 low"), lo, half_of(2'(c)));
        chk(ec == 1, "R6 pulses per period", ec, 1);
        chk(el == 1, "R6 pulse in last low cycle", el, 1);
      end
    end

    // R5: run-time switches between every ordered pair at several offsets
    for (int f = 0; f < 3; f++) begin
      for (int t = 0; t < 3; t++) begin
        if (f == t) continue;
        for (int k = 0; k < 4; k++) begin
          int hf, ht;
          bit moved;
          hf = half_of(2'(f)); ht = half_of(2'(t));
          speed_sel = 2'(f);
          repeat (100) @(negedge clk);
          grab(hi, lo, ec, el);
          repeat (offs[k] % (2 * hf)) @(negedge clk);
          speed_sel = 2'(t);
          moved = 1'b0;
          for (int p = 0; p < 4; p++) begin
            grab(hi, lo, ec, el);
            chk(hi == lo, "R5 equal phases", hi, lo);
            chk(hi == hf || hi == ht, "R5 legal high", hi, ht);
            if (moved) chk(hi == ht, "R5 no return to old rate", hi, ht);
            if (hi == ht) moved = 1'b1;
            chk(ec == 1, "R6 pulse after switch", ec, 1);
            if (p == 3) chk(hi == ht, "R5 new rate reached", hi, ht);
          end
        end
      end
    end

    // R7 R8 R9: pad control combinations
    speed_sel = 2'b01;
    for (int m = 0; m < 4; m++) begin
      clkout_inv = m[0];
      clkout_hiz = m[1];
      repeat (3) @(negedge clk);
      for (int s = 0; s < 45; s++) begin
        if (clkout_hiz) begin
          chk(clkout_oe == 0, "R8 oe off", int'(clkout_oe), 0);
          chk(clkout_pad == 0, "R8 pad held low", int'(clkout_pad), 0);
        end else if (clkout_inv) begin
          chk(clkout_oe == 1, "R7 oe on", int'(clkout_oe), 1);
          chk(clkout_pad == ~cpu_clk, "R7 inverted pad", int'(clkout_pad), int'(~cpu_clk));
        end else begin
          chk(clkout_oe == 1, "R9 oe on", int'(clkout_oe), 1);
          chk(clkout_pad == cpu_clk, "R9 pad follows", int'(clkout_pad), int'(cpu_clk));
        end
        @(negedge clk);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule